// File: doc/BRIEF.md
# NOR Flash Command Decoder

This block models the command side of a 16-bit NOR flash on top of a small internal word array. A host issues bus cycles on a request channel. Writes are fed to a sequence matcher that looks for the two-write unlock pattern followed by a command word. A matched sequence starts a word program, a sector erase or a whole-array erase, or moves the block into or out of an identification mode. Program and erase operations keep the block busy for a set number of clocks. The durations are parameters, so a bench can keep them short.

While an operation is running, every read returns a status word whose two toggle bits flip from one read to the next, in place of array data. Any write made during that time is dropped. A write that does not fit the expected next step of a sequence sends the matcher back to its start and changes nothing. Programming can only clear bits, and erasing sets cells to all ones.

The request channel uses valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. Each accepted read returns exactly one response on the next cycle. The response is held, with `rsp_data` stable, until `rsp_ready` is high. While a response is waiting, `req_ready` is low. Accepted writes return no response.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, the block is not in identification mode, and every array word reads 0xFFFF.
- R2: The writes 0x00AA at 0x5555, then 0x0055 at 0x2AAA, then 0x00A0 at 0x5555, followed by any write (A, D), start a program of word A. Word A is stored as its old value AND D.
- R3: A program can only clear bits: programming 0xFF0F over 0x1234 leaves 0x1204.
- R4: The unlock pair, 0x0080 at 0x5555, a second unlock pair, then 0x0030 at any address sets every word of the sector containing that address (SECTOR_WORDS words, aligned) to 0xFFFF. Words in other sectors keep their values.
- R5: The same prefix, ending in 0x0010 at 0x5555 instead, sets every array word to 0xFFFF.
- R6: A write that does not match the expected next step returns the matcher to idle. It does not start an operation and does not change the array. A correct sequence afterwards still works.
- R7: While busy, reads return status in place of data. The first status read after a start returns 0x0044 (bits 6 and 2 set). Each further status read alternates with 0x0000.
- R8: An operation triggered at clock edge T0 makes reads accepted at edges T1 through TD return status, where D is PROG_CYCLES, SERASE_CYCLES or CERASE_CYCLES. A read accepted at edge TD+1 returns array data.
- R9: Writes accepted while busy are ignored, including a write in the last busy cycle. The matcher restarts from idle when the busy period ends.
- R10: After the unlock pair and 0x0090 at 0x5555, reads return the following: 0x00BF at address 0, DEVICE_CODE at address 1, and 0x0000 at any other address.
- R11: The unlock pair and 0x00F0 at 0x5555 leave identification mode, and reads return array data again.
- R12: A read accepted at an edge shows `rsp_valid` from the next cycle. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_data` stays stable and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 16 | Read data, status word or identification code |

## Verification
Two things can fall in the same cycle: the end of a busy period, and either a stalled read response or an incoming command write. The bench captures a status read one cycle before the busy period ends and holds `rsp_ready` low across that end. It then checks that the held word is still the status value and does not switch to array data. In a second test, it places the first unlock write exactly on the last busy edge. The whole sequence must then fail to program, while the same sequence one cycle later succeeds.

// File: rtl/nor_pkg.sv
package nor_pkg;
  localparam int DATA_W = 16;
  localparam int SEQ_AW = 15;

  localparam logic [SEQ_AW-1:0] UNLOCK_ADDR_A = 15'h5555;
  localparam logic [SEQ_AW-1:0] UNLOCK_ADDR_B = 15'h2AAA;

  localparam logic [DATA_W-1:0] KEY_FIRST    = 16'h00AA;
  localparam logic [DATA_W-1:0] KEY_SECOND   = 16'h0055;
  localparam logic [DATA_W-1:0] OP_PROGRAM   = 16'h00A0;
  localparam logic [DATA_W-1:0] OP_ERASE_PFX = 16'h0080;
  localparam logic [DATA_W-1:0] OP_ID_ON     = 16'h0090;
  localparam logic [DATA_W-1:0] OP_ID_OFF    = 16'h00F0;
  localparam logic [DATA_W-1:0] OP_SECT_ERS  = 16'h0030;
  localparam logic [DATA_W-1:0] OP_FULL_ERS  = 16'h0010;

  localparam logic [DATA_W-1:0] MAKER_CODE   = 16'h00BF;
  localparam logic [DATA_W-1:0] TOGGLE_MASK  = 16'h0044;
  localparam logic [DATA_W-1:0] ERASED_WORD  = 16'hFFFF;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_PGM_DATA,
    SQ_ERS_ARMED,
    SQ_ERS_KEY1,
    SQ_ERS_KEY2
  } seq_state_t;

  typedef struct packed {
    logic prog;
    logic sect_erase;
    logic full_erase;
    logic id_on;
    logic id_off;
  } nor_cmd_t;
endpackage

// File: rtl/nor_seq_matcher.sv
module nor_seq_matcher
  import nor_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEQ_AW-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output nor_cmd_t            cmd
);
  seq_state_t st_q, st_d;

  logic at_a, at_b;
  assign at_a = (wr_addr == UNLOCK_ADDR_A);
  assign at_b = (wr_addr == UNLOCK_ADDR_B);

  always_comb begin
    st_d = st_q;
    cmd  = '0;
    if (wr_en) begin
      st_d = SQ_IDLE;
      unique case (st_q)
        SQ_IDLE: if (at_a && wr_data == KEY_FIRST) st_d = SQ_KEY1;
        SQ_KEY1: if (at_b && wr_data == KEY_SECOND) st_d = SQ_KEY2;
        SQ_KEY2: begin
          if (at_a) begin
            if (wr_data == OP_PROGRAM)        st_d = SQ_PGM_DATA;
            else if (wr_data == OP_ERASE_PFX) st_d = SQ_ERS_ARMED;
            else if (wr_data == OP_ID_ON)     cmd.id_on = 1'b1;
            else if (wr_data == OP_ID_OFF)    cmd.id_off = 1'b1;
          end
        end
        SQ_PGM_DATA:  cmd.prog = 1'b1;
        SQ_ERS_ARMED: if (at_a && wr_data == KEY_FIRST) st_d = SQ_ERS_KEY1;
        SQ_ERS_KEY1:  if (at_b && wr_data == KEY_SECOND) st_d = SQ_ERS_KEY2;
        SQ_ERS_KEY2: begin
          if (wr_data == OP_SECT_ERS)             cmd.sect_erase = 1'b1;
          else if (at_a && wr_data == OP_FULL_ERS) cmd.full_erase = 1'b1;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  // R6: at most one command fires per write
  p_one_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd.prog, cmd.sect_erase, cmd.full_erase, cmd.id_on, cmd.id_off}));

  // R6: a command pulse always leaves the matcher idle for the next cycle
  p_cmd_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != '0) |=> (st_q == SQ_IDLE));
endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer
  import nor_pkg::*;
#(
  parameter int PROG_CYCLES   = 8,
  parameter int SERASE_CYCLES = 64,
  parameter int CERASE_CYCLES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic              start_sect,
  input  logic              start_full,
  input  logic              status_rd,
  output logic              busy,
  output logic [DATA_W-1:0] status_word
);
  localparam int MAX_A  = (PROG_CYCLES > SERASE_CYCLES) ? PROG_CYCLES : SERASE_CYCLES;
  localparam int MAX_D  = (MAX_A > CERASE_CYCLES) ? MAX_A : CERASE_CYCLES;
  localparam int CNT_W  = $clog2(MAX_D + 1);

  logic [CNT_W-1:0] remain_q;
  logic             tog_q;
  logic             any_start;

  assign any_start   = start_prog | start_sect | start_full;
  assign busy        = (remain_q != '0);
  assign status_word = tog_q ? TOGGLE_MASK : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      tog_q    <= 1'b0;
    end else if (any_start) begin
      tog_q <= 1'b1;
      if (start_prog)      remain_q <= CNT_W'(PROG_CYCLES);
      else if (start_sect) remain_q <= CNT_W'(SERASE_CYCLES);
      else                 remain_q <= CNT_W'(CERASE_CYCLES);
    end else begin
      if (busy)      remain_q <= remain_q - 1'b1;
      if (status_rd) tog_q <= ~tog_q;
    end
  end

  // R8: any start makes the block busy on the next cycle
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_start |=> busy);

  // R7: consecutive status reads see a different word
  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && busy && !any_start) |=> (status_word != $past(status_word)));
endmodule

// File: rtl/nor_word_array.sv
module nor_word_array
  import nor_pkg::*;
#(
  parameter int WORDS       = 256,
  parameter int SECT_WORDS  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          prog_en,
  input  logic [$clog2(WORDS)-1:0]      prog_idx,
  input  logic [DATA_W-1:0]             prog_data,
  input  logic                          sect_en,
  input  logic [$clog2(WORDS)-$clog2(SECT_WORDS)-1:0] sect_idx,
  input  logic                          full_en,
  input  logic [$clog2(WORDS)-1:0]      rd_idx,
  output logic [DATA_W-1:0]             rd_data
);
  localparam int AW = $clog2(WORDS);
  localparam int SW = $clog2(SECT_WORDS);

  logic [DATA_W-1:0] mem [WORDS];

  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || full_en) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= ERASED_WORD;
    end else if (sect_en) begin
      for (int i = 0; i < SECT_WORDS; i++) mem[{sect_idx, SW'(i)}] <= ERASED_WORD;
    end else if (prog_en) begin
      mem[prog_idx] <= mem[prog_idx] & prog_data;
    end
  end

  initial begin
    if (AW <= SW) $error("array must hold more than one sector");
  end
endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash
  import nor_pkg::*;
#(
  parameter int              ADDR_W        = 16,
  parameter int              ARRAY_WORDS   = 256,
  parameter int              SECTOR_WORDS  = 16,
  parameter int              PROG_CYCLES   = 8,
  parameter int              SERASE_CYCLES = 64,
  parameter int              CERASE_CYCLES = 128,
  parameter logic [15:0]     DEVICE_CODE   = 16'h2468
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_data
);
  localparam int AW = $clog2(ARRAY_WORDS);
  localparam int SW = $clog2(SECTOR_WORDS);

  logic              accept, wr_acc, rd_acc, wr_live;
  logic              busy, status_rd;
  logic              id_mode_q;
  logic [DATA_W-1:0] status_word, arr_word, id_word;
  nor_cmd_t          cmd;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_acc    = accept && req_write;
  assign rd_acc    = accept && !req_write;
  assign wr_live   = wr_acc && !busy;
  assign status_rd = rd_acc && busy;

  nor_seq_matcher u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_live),
    .wr_addr (req_addr[SEQ_AW-1:0]),
    .wr_data (req_wdata),
    .cmd     (cmd)
  );

  nor_busy_timer #(
    .PROG_CYCLES   (PROG_CYCLES),
    .SERASE_CYCLES (SERASE_CYCLES),
    .CERASE_CYCLES (CERASE_CYCLES)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_prog  (cmd.prog),
    .start_sect  (cmd.sect_erase),
    .start_full  (cmd.full_erase),
    .status_rd   (status_rd),
    .busy        (busy),
    .status_word (status_word)
  );

  nor_word_array #(
    .WORDS      (ARRAY_WORDS),
    .SECT_WORDS (SECTOR_WORDS)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_en   (cmd.prog),
    .prog_idx  (req_addr[AW-1:0]),
    .prog_data (req_wdata),
    .sect_en   (cmd.sect_erase),
    .sect_idx  (req_addr[AW-1:SW]),
    .full_en   (cmd.full_erase),
    .rd_idx    (req_addr[AW-1:0]),
    .rd_data   (arr_word)
  );

  always_comb begin
    if (req_addr == ADDR_W'(0))      id_word = MAKER_CODE;
    else if (req_addr == ADDR_W'(1)) id_word = DEVICE_CODE;
    else                             id_word = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         id_mode_q <= 1'b0;
    else if (cmd.id_on) id_mode_q <= 1'b1;
    else if (cmd.id_off) id_mode_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      if (busy)           rsp_data <= status_word;
      else if (id_mode_q) rsp_data <= id_word;
      else                rsp_data <= arr_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R12: a stalled response is held unchanged
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R12: every accepted read produces a response next cycle
  p_rd_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);

  // R9: no operation can start while one is running
  p_no_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(cmd.prog || cmd.sect_erase || cmd.full_erase));

  initial begin
    if (ADDR_W < SEQ_AW || ADDR_W < AW) $error("ADDR_W too narrow");
  end
endmodule

// File: tb/test_nor_cmd_flash.sv
module test_nor_cmd_flash;
  localparam int CLK_P = 10;
  localparam int D_P = 10;
  localparam int D_S = 20;
  localparam int D_C = 30;
  localparam logic [15:0] DEV = 16'h2468;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] model [256];

  always #(CLK_P/2) clk = ~clk;

  nor_cmd_flash #(
    .ADDR_W(16), .ARRAY_WORDS(256), .SECTOR_WORDS(16),
    .PROG_CYCLES(D_P), .SERASE_CYCLES(D_S), .CERASE_CYCLES(D_C),
    .DEVICE_CODE(DEV)
  ) i_nor_cmd_flash (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare each delivered response against the scoreboard
  always begin
    logic [15:0] e;
    string t;
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R12: actual=%h expected=none (unexpected response)", rsp_data);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_data, e, t);
      end
    end
  end

  task automatic wait_ready();
    #(CLK_P/4);
    while (!req_ready) begin
      @(negedge clk);
      #(CLK_P/4);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [15:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    wait_ready();
  endtask

  task automatic bus_rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    wait_ready();
  endtask

  task automatic cmd3(input logic [15:0] op);
    bus_wr(16'h5555, 16'h00AA);
    bus_wr(16'h2AAA, 16'h0055);
    bus_wr(16'h5555, op);
  endtask

  task automatic erase_prefix();
    cmd3(16'h0080);
    bus_wr(16'h5555, 16'h00AA);
    bus_wr(16'h2AAA, 16'h0055);
  endtask

  task automatic prog_word(input logic [15:0] a, input logic [15:0] d);
    cmd3(16'h00A0);
    bus_wr(a, d);
    model[a[7:0]] = model[a[7:0]] & d;
    repeat (D_P) @(negedge clk);
  endtask

  // Called right after the trigger edge T0: reads at T1..T3 and TD see
  // status, the read at TD+1 sees data.
  task automatic op_timing(input int d, input logic [15:0] a, input string tag);
    bus_rd(a, 16'h0044, {tag, " first status"});
    bus_rd(a, 16'h0000, {tag, " second status"});
    bus_rd(a, 16'h0044, {tag, " third status"});
    repeat (d - 4) @(negedge clk);
    bus_rd(a, 16'h0000, {tag, " last busy cycle"});
    bus_rd(a, model[a[7:0]], {tag, " first free cycle"});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #(CLK_P/4);
    check({15'b0, req_ready}, 16'h1, "R1 req_ready");
    check({15'b0, rsp_valid}, 16'h0, "R1 rsp_valid");
    @(negedge clk);
    bus_rd(16'h0010, 16'hFFFF, "R1 erased array");
    bus_rd(16'h0000, 16'hFFFF, "R1 not in id mode");

    // R2 / R3 program
    prog_word(16'h0003, 16'h1234);
    bus_rd(16'h0003, 16'h1234, "R2 program");
    prog_word(16'h0040, 16'hA5A5);
    bus_rd(16'h0040, 16'hA5A5, "R2 program second word");
    prog_word(16'h0003, 16'hFF0F);
    bus_rd(16'h0003, 16'h1204, "R3 clear only");

    // R7 / R8 program timing
    cmd3(16'h00A0);
    bus_wr(16'h0050, 16'h0F0F);
    model[8'h50] = 16'h0F0F;
    op_timing(D_P, 16'h0050, "R7 R8 program");

    // R4 sector erase
    prog_word(16'h0013, 16'h0001);
    prog_word(16'h0023, 16'h0002);
    erase_prefix();
    bus_wr(16'h0018, 16'h0030);
    for (int i = 16; i < 32; i++) model[i] = 16'hFFFF;
    op_timing(D_S, 16'h0013, "R4 R8 sector erase");
    bus_rd(16'h001F, 16'hFFFF, "R4 sector end");
    bus_rd(16'h0023, 16'h0002, "R4 next sector kept");
    bus_rd(16'h0003, 16'h1204, "R4 other sector kept");

    // R5 chip erase
    erase_prefix();
    bus_wr(16'h5555, 16'h0010);
    for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
    op_timing(D_C, 16'h0023, "R5 R8 chip erase");
    bus_rd(16'h0003, 16'hFFFF, "R5 word 3");
    bus_rd(16'h0050, 16'hFFFF, "R5 word 0x50");

    // R6 mismatches
    bus_wr(16'h5555, 16'h00AA);
    bus_wr(16'h2AAA, 16'h0055);
    bus_wr(16'h5554, 16'h00A0);
    bus_wr(16'h0007, 16'h0000);
    bus_rd(16'h0007, 16'hFFFF, "R6 wrong command address");
    bus_wr(16'h5555, 16'h00AA);
    bus_wr(16'h2AAA, 16'h0056);
    bus_wr(16'h5555, 16'h00A0);
    bus_wr(16'h0008, 16'h0000);
    bus_rd(16'h0008, 16'hFFFF, "R6 wrong unlock data");
    erase_prefix();
    bus_wr(16'h0000, 16'h0020);
    bus_rd(16'h0000, 16'hFFFF, "R6 bad erase code no busy");
    prog_word(16'h0007, 16'h00F0);
    bus_rd(16'h0007, 16'h00F0, "R6 recovery program");

    // R9 writes during busy ignored
    prog_word(16'h0060, 16'h3333);
    bus_rd(16'h0060, 16'h3333, "R9 base program");
    cmd3(16'h00A0);
    bus_wr(16'h0070, 16'h7777);
    model[8'h70] = 16'h7777;
    repeat (D_P - 1) @(negedge clk);
    cmd3(16'h00A0);
    bus_wr(16'h0071, 16'h0000);
    bus_rd(16'h0071, 16'hFFFF, "R9 sequence from last busy cycle");
    cmd3(16'h00A0);
    bus_wr(16'h0072, 16'h0000);
    cmd3(16'h00A0);
    bus_wr(16'h0073, 16'h0000);
    repeat (D_P) @(negedge clk);
    bus_rd(16'h0073, 16'hFFFF, "R9 sequence inside busy");
    bus_rd(16'h0072, 16'h0000, "R9 program before busy");
    model[8'h72] = 16'h0000;
    prog_word(16'h0071, 16'h1111);
    bus_rd(16'h0071, 16'h1111, "R9 program after busy");

    // R10 / R11 identification mode
    cmd3(16'h0090);
    bus_rd(16'h0000, 16'h00BF, "R10 maker code");
    bus_rd(16'h0001, DEV, "R10 device code");
    bus_rd(16'h0003, 16'h0000, "R10 other address");
    cmd3(16'h00F0);
    bus_rd(16'h0071, 16'h1111, "R11 array after exit");
    bus_rd(16'h0001, 16'hFFFF, "R11 word 1 after exit");

    // R12 back-pressure across the end of busy
    cmd3(16'h00A0);
    bus_wr(16'h0080, 16'h0808);
    model[8'h80] = 16'h0808;
    repeat (D_P - 2) @(negedge clk);
    rsp_ready = 1'b0;
    bus_rd(16'h0080, 16'h0044, "R12 held status released");
    for (int k = 0; k < 4; k++) begin
      #(CLK_P/4);
      check({15'b0, rsp_valid}, 16'h1, "R12 valid held");
      check({15'b0, req_ready}, 16'h0, "R12 ready low");
      check(rsp_data, 16'h0044, "R12 data held past busy end");
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    bus_rd(16'h0080, 16'h0808, "R12 data after release");

    repeat (4) @(negedge clk);
    check(16'(exp_q.size()), 16'h0, "R12 all responses delivered");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule